// File: doc/BRIEF.md
# Shift-Register Counted Raster Timing Generator

This block produces the horizontal sync, vertical sync, display-enable and frame-start strobes for a raster display. It does not use binary position counters. Each axis steps a 16-bit linear feedback shift register, which keeps the next-state logic to a single XOR level and a wire shift. Every programmable position (window opens, window closes, last position) is supplied as the register state that the axis reaches after the required number of steps. Software therefore converts ordinal counts into that state space before it writes them.

Equality comparators detect each programmed state. Register states carry no order, so "between A and B" is tracked with a set/clear flag per window rather than a magnitude compare. The horizontal axis advances on every pixel clock. The vertical axis advances once per line. A blanking-mode input can suppress both syncs while the raster keeps running.

Top module: `lfsr_timing_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four outputs are 0 after that edge. Both axis registers hold the seed, so the first clock after reset is position 0 of line 0.
- R2: An axis state steps by shifting left by one bit, with the new bit 0 equal to the XOR of the old bits 15, 4, 2 and 1. The seed is 16'hFFFF, and position n is the state after n steps from the seed.
- R3: In the clock when the horizontal state equals `h_last`, the horizontal axis reloads the seed on the next clock. A line whose `h_last` is position N therefore lasts N+1 clocks.
- R4: The vertical axis steps once at each horizontal reload. It reloads the seed at the horizontal reload of the line whose vertical state equals `v_last`, so a frame with `v_last` at line M holds M+1 lines.
- R5: `de_o` is high for horizontal positions from `h_act_start` (inclusive) to `h_act_stop` (exclusive) on lines from `v_act_start` (inclusive) to `v_act_stop` (exclusive). A window that has not closed by the end of its line or frame closes at the reload.
- R6: `hsync_o` is active-high for horizontal positions from `h_pulse_on` (inclusive) to `h_pulse_off` (exclusive), and closes at the line reload.
- R7: `vsync_o` is active-high on lines from `v_pulse_on` (inclusive) to `v_pulse_off` (exclusive), and closes at the frame reload.
- R8: When `blank_mode` is 8'h01, 8'h05 or 8'h07, both syncs are 0. Any other value, 8'h00 included, leaves the syncs normal. `de_o`, `frame_start_o` and the raster position are unaffected by `blank_mode`.
- R9: `frame_start_o` is high for exactly one clock, for the last position of the last line of each frame. This puts frame starts (last line + 1) × (line length) clocks apart.
- R10: All outputs are registered. Each reflects the position, and the `blank_mode`, of the clock before it.

Start positions, stop positions and the last positions must be distinct states within each axis's range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| h_act_start | input | 16 | State at which the horizontal display window opens |
| h_act_stop | input | 16 | State at which the horizontal display window closes |
| h_last | input | 16 | State of the last position in a line |
| h_pulse_on | input | 16 | State at which horizontal sync begins |
| h_pulse_off | input | 16 | State at which horizontal sync ends |
| v_act_start | input | 16 | Line state at which the vertical display window opens |
| v_act_stop | input | 16 | Line state at which the vertical display window closes |
| v_last | input | 16 | State of the last line in a frame |
| v_pulse_on | input | 16 | Line state at which vertical sync begins |
| v_pulse_off | input | 16 | Line state at which vertical sync ends |
| blank_mode | input | 8 | Blanking mode; 8'h01, 8'h05 and 8'h07 suppress both syncs |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Display enable |
| frame_start_o | output | 1 | One-clock pulse at the end of each frame |

## Verification
A wrong horizontal state or a bad tap shows up within one line. Sync and display-enable edges move away from the positions the bench derives from ordinal counts, and the line period changes. A vertical axis that steps at the wrong time, or reloads on the wrong line, shows up as a wrong vsync or display-enable line within one frame and as a wrong spacing between frame-start pulses. A window flag that fails to set, clear or close at the reload changes display-enable or a sync on the very next clock, and the bench compares every output on every clock.

// File: rtl/lfsr_tg_pkg.sv
// Shared constants, state type and step function for the LFSR raster timer.
// Assumes a 16-bit Fibonacci register with taps at bits 15, 4, 2 and 1.
package lfsr_tg_pkg;
    localparam int          LFSR_W  = 16;
    localparam int          MODE_W  = 8;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hFFFF;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'h8016;

    localparam logic [MODE_W-1:0] MODE_SUSPEND  = 8'h01;
    localparam logic [MODE_W-1:0] MODE_STANDBY  = 8'h05;
    localparam logic [MODE_W-1:0] MODE_POWEROFF = 8'h07;

    typedef logic [LFSR_W-1:0] lfsr_t;

    // One step: shift left, feed back the XOR of the tapped bits into bit 0.
    function automatic lfsr_t lfsr_step(input lfsr_t s);
        return {s[LFSR_W-2:0], ^(s & LFSR_TAPS)};
    endfunction
endpackage

// File: rtl/lfsr_axis_ctr.sv
// One raster axis counted in LFSR state space.
// Steps when adv is high; reloads the seed when it steps from end_val.
// Assumes end_val is reachable from the seed.
module lfsr_axis_ctr
    import lfsr_tg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv,
    input  lfsr_t end_val,
    output lfsr_t state,
    output logic  wrap
);
    lfsr_t state_q;

    assign state = state_q;
    assign wrap  = adv && (state_q == end_val);

    // Axis state: seed on reset or wrap, next LFSR state on advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= LFSR_SEED;
        else if (adv)
            state_q <= wrap ? LFSR_SEED : lfsr_step(state_q);
    end

    // R3 R4: a wrap always lands on the seed
    a_r3_reload_seed: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (state_q == LFSR_SEED));

    // R4: without an advance the axis holds its position
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(state_q));
endmodule

// File: rtl/lfsr_window.sv
// Open/close window over unordered LFSR states.
// act is high from the state matching open_val up to (not including) the
// state matching close_val; open wins if both match. The flag is updated
// on adv and cleared when clr accompanies it (end of line or frame).
module lfsr_window
    import lfsr_tg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv,
    input  logic  clr,
    input  lfsr_t state,
    input  lfsr_t open_val,
    input  lfsr_t close_val,
    output logic  act
);
    logic flag_q;

    // Window status at the current state, falling back to the held flag.
    always_comb begin
        if (state == open_val)
            act = 1'b1;
        else if (state == close_val)
            act = 1'b0;
        else
            act = flag_q;
    end

    // Held flag: carries the window status to the following positions.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (adv)
            flag_q <= clr ? 1'b0 : act;
    end

    // R5: the flag only moves on its axis advance
    a_r5_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(flag_q));
endmodule

// File: rtl/lfsr_timing_gen.sv
// Raster timing generator counting pixels and lines with LFSRs.
// All position inputs are LFSR states (position n = n steps from the seed)
// and are assumed stable while the raster runs. Outputs are registered.
module lfsr_timing_gen
    import lfsr_tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LFSR_W-1:0] h_act_start,
    input  logic [LFSR_W-1:0] h_act_stop,
    input  logic [LFSR_W-1:0] h_last,
    input  logic [LFSR_W-1:0] h_pulse_on,
    input  logic [LFSR_W-1:0] h_pulse_off,
    input  logic [LFSR_W-1:0] v_act_start,
    input  logic [LFSR_W-1:0] v_act_stop,
    input  logic [LFSR_W-1:0] v_last,
    input  logic [LFSR_W-1:0] v_pulse_on,
    input  logic [LFSR_W-1:0] v_pulse_off,
    input  logic [MODE_W-1:0] blank_mode,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic              frame_start_o
);
    lfsr_t h_state, v_state;
    logic  h_wrap, v_wrap;
    logic  h_de, v_de, h_sy, v_sy;
    logic  sync_off;

    lfsr_axis_ctr u_hctr (
        .clk(clk), .rst_n(rst_n), .adv(1'b1), .end_val(h_last),
        .state(h_state), .wrap(h_wrap)
    );

    lfsr_axis_ctr u_vctr (
        .clk(clk), .rst_n(rst_n), .adv(h_wrap), .end_val(v_last),
        .state(v_state), .wrap(v_wrap)
    );

    lfsr_window u_hde (
        .clk(clk), .rst_n(rst_n), .adv(1'b1), .clr(h_wrap),
        .state(h_state), .open_val(h_act_start), .close_val(h_act_stop),
        .act(h_de)
    );

    lfsr_window u_vde (
        .clk(clk), .rst_n(rst_n), .adv(h_wrap), .clr(v_wrap),
        .state(v_state), .open_val(v_act_start), .close_val(v_act_stop),
        .act(v_de)
    );

    lfsr_window u_hsy (
        .clk(clk), .rst_n(rst_n), .adv(1'b1), .clr(h_wrap),
        .state(h_state), .open_val(h_pulse_on), .close_val(h_pulse_off),
        .act(h_sy)
    );

    lfsr_window u_vsy (
        .clk(clk), .rst_n(rst_n), .adv(h_wrap), .clr(v_wrap),
        .state(v_state), .open_val(v_pulse_on), .close_val(v_pulse_off),
        .act(v_sy)
    );

    // Blanking decode: the three power-saving codes silence both syncs.
    always_comb begin
        sync_off = (blank_mode == MODE_SUSPEND) ||
                   (blank_mode == MODE_STANDBY) ||
                   (blank_mode == MODE_POWEROFF);
    end

    // Output registers: one clock after the position they describe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_o       <= 1'b0;
            vsync_o       <= 1'b0;
            de_o          <= 1'b0;
            frame_start_o <= 1'b0;
        end else begin
            hsync_o       <= h_sy && !sync_off;
            vsync_o       <= v_sy && !sync_off;
            de_o          <= h_de && v_de;
            frame_start_o <= v_wrap;
        end
    end

    // R8: a suppressing mode leaves both syncs low on the next clock
    a_r8_blank_syncs: assert property (@(posedge clk) disable iff (!rst_n)
        sync_off |=> (!hsync_o && !vsync_o));

    // R9: frame start lasts one clock when a line is longer than one clock
    a_r9_fs_single: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_o && (h_last != LFSR_SEED)) |=> !frame_start_o);
endmodule

// File: tb/lfsr_timing_gen_bench.sv
// Self-checking bench: ordinal-count model of the raster against the design.
module lfsr_timing_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] h_act_start, h_act_stop, h_last, h_pulse_on, h_pulse_off;
    logic [15:0] v_act_start, v_act_stop, v_last, v_pulse_on, v_pulse_off;
    logic [7:0]  blank_mode = 8'h00;
    logic        hsync_o, vsync_o, de_o, frame_start_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lfsr_timing_gen u_lfsr_timing_gen (
        .clk(clk), .rst_n(rst_n),
        .h_act_start(h_act_start), .h_act_stop(h_act_stop), .h_last(h_last),
        .h_pulse_on(h_pulse_on), .h_pulse_off(h_pulse_off),
        .v_act_start(v_act_start), .v_act_stop(v_act_stop), .v_last(v_last),
        .v_pulse_on(v_pulse_on), .v_pulse_off(v_pulse_off),
        .blank_mode(blank_mode),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .frame_start_o(frame_start_o)
    );

    // R2: state after n steps from 16'hFFFF, taps 15,4,2,1 into bit 0
    function automatic logic [15:0] lfsr_at(input int n);
        logic [15:0] s = 16'hFFFF;
        for (int i = 0; i < n; i++)
            s = {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
        return s;
    endfunction

    function automatic bit mode_mutes(input logic [7:0] m);
        return (m == 8'h01) || (m == 8'h05) || (m == 8'h07);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Program one timing (ordinal counts), reset, then check every clock.
    task automatic run_cfg(input int htot, input int hds, input int hde, input int hsw,
                           input int vtot, input int vds, input int vde, input int vsw,
                           input int frames, input bit vary_mode);
        int hi = 0;
        int vi = 0;
        int cyc = 0;
        int last_fs = -1;
        int last_hs_rise = -1;
        bit prev_hs = 1'b0;
        bit e_hs, e_vs, e_de, e_fs;
        @(negedge clk);
        rst_n = 1'b0;
        blank_mode = 8'h00;
        h_last = lfsr_at(htot - 1);
        h_act_start = lfsr_at(hds);
        h_act_stop = lfsr_at(hde);
        h_pulse_on = lfsr_at(1);
        h_pulse_off = lfsr_at(hsw + 1);
        v_last = lfsr_at(vtot - 1);
        v_act_start = lfsr_at(vds);
        v_act_stop = lfsr_at(vde);
        v_pulse_on = lfsr_at(0);
        v_pulse_off = lfsr_at(vsw);
        repeat (2) @(negedge clk);
        // R1: outputs low while held in reset
        check({hsync_o, vsync_o, de_o, frame_start_o} == 4'b0000, "R1 reset outputs",
              {hsync_o, vsync_o, de_o, frame_start_o}, 0);
        rst_n = 1'b1;
        repeat (frames * htot * vtot) begin
            if (vary_mode && ($urandom_range(0, 15) == 0)) begin
                case ($urandom_range(0, 4))
                    0: blank_mode = 8'h00;
                    1: blank_mode = 8'h01;
                    2: blank_mode = 8'h05;
                    3: blank_mode = 8'h07;
                    default: blank_mode = 8'h03;
                endcase
            end
            @(posedge clk);
            e_hs = (hi >= 1) && (hi < hsw + 1) && !mode_mutes(blank_mode);
            e_vs = (vi < vsw) && !mode_mutes(blank_mode);
            e_de = (hi >= hds) && (hi < hde) && (vi >= vds) && (vi < vde);
            e_fs = (hi == htot - 1) && (vi == vtot - 1);
            if (hi == htot - 1) begin
                hi = 0;
                vi = (vi == vtot - 1) ? 0 : vi + 1;
            end else begin
                hi++;
            end
            @(negedge clk);
            cyc++;
            check(hsync_o == e_hs, "R6 R8 R10 hsync", hsync_o, e_hs);
            check(vsync_o == e_vs, "R7 R8 R10 vsync", vsync_o, e_vs);
            check(de_o == e_de, "R5 R10 de", de_o, e_de);
            check(frame_start_o == e_fs, "R9 frame_start", frame_start_o, e_fs);
            if (frame_start_o) begin
                if (last_fs >= 0)
                    check(cyc - last_fs == htot * vtot, "R4 R9 frame period",
                          cyc - last_fs, htot * vtot);
                last_fs = cyc;
            end
            if (!vary_mode && hsync_o && !prev_hs) begin
                if (last_hs_rise >= 0)
                    check(cyc - last_hs_rise == htot, "R2 R3 line period",
                          cyc - last_hs_rise, htot);
                last_hs_rise = cyc;
            end
            prev_hs = hsync_o;
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        // Directed: typical small timing
        run_cfg(20, 4, 16, 2, 8, 1, 6, 1, 3, 1'b0);
        // Directed corners: windows open at the seed and close at the wrap (R5)
        run_cfg(12, 0, 12, 10, 6, 0, 6, 5, 3, 1'b0);
        // Directed: one-line sync, narrow display (R6 R7)
        run_cfg(9, 3, 4, 1, 5, 2, 3, 1, 3, 1'b0);
        // Directed: blanking modes toggled while running (R8)
        run_cfg(16, 3, 13, 3, 7, 1, 6, 2, 4, 1'b1);
        // Random timings
        for (int k = 0; k < 6; k++) begin
            int ht, hs, he, hw, vt, vs, ve, vw;
            ht = $urandom_range(8, 40);
            hs = $urandom_range(0, ht - 2);
            he = $urandom_range(hs + 1, ht);
            hw = $urandom_range(1, ht - 1);
            vt = $urandom_range(3, 12);
            vs = $urandom_range(0, vt - 2);
            ve = $urandom_range(vs + 1, vt);
            vw = $urandom_range(1, vt - 1);
            run_cfg(ht, hs, he, hw, vt, vs, ve, vw, 3, k[0]);
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule